// File: doc/BRIEF.md
# CCD Frame Readout Sequencer

This block is the frame-level controller of a timing generator for a full-frame CCD camera. It watches an exposure trigger. When the trigger rises, it opens a charge-reset window that clears the image area. It then keeps the image clocks quiet for as long as the trigger stays high, which is the integration period. After the trigger falls, it walks through every line of the sensor. For each line it asks a separate line-timing block to perform one line shift and horizontal readout, and it waits for that block to report completion before starting the next line. The waveforms inside a line are generated elsewhere, and so are analog levels and drivers.

Each frame has a fixed layout: 6 leading black lines, 5344 active lines and 6 trailing black lines, for 5356 lines in total. Each line start carries three pieces of information:
- a line index from 0 to 5355;
- a tag telling the downstream block whether the line is black or active;
- in subsampling mode, a skip tag. It asks for the line to be shifted while the transfer gate is held low, so that line is discarded.

A one-clock frame-done pulse marks the return to idle. Trigger edges that arrive while a frame is in progress are ignored.

States:
- `SEQ_IDLE`: waits for a trigger rising edge.
- `SEQ_CLEAR`: charge reset is active for a fixed number of clocks.
- `SEQ_EXPOSE`: integration is in progress.
- `SEQ_ISSUE`: the one-cycle line start.
- `SEQ_WAIT`: waits for the line-done handshake.
- `SEQ_DONE`: the frame-done pulse.

Transitions:
- IDLE to CLEAR on a trigger rising edge.
- CLEAR to EXPOSE when the reset window ends and the trigger is still high.
- CLEAR to ISSUE when the reset window ends and the trigger is already low.
- EXPOSE to ISSUE when the trigger is low.
- ISSUE to WAIT always.
- WAIT to ISSUE on line done when the current line is not the last one.
- WAIT to DONE on line done when the current line is the last one.
- DONE to IDLE always.

Top module: `ccd_frame_sequencer`

## Requirements
- R1: A frame issues exactly 5356 line starts, with indices 0 to 5355 in increasing order. `line_active` is 1 for indices 6 to 5349 and 0 for indices 0 to 5 and 5350 to 5355.
- R2: `cr_pulse` is high for exactly CR_CLKS consecutive clocks (default 500). It rises on the first edge at which the sequencer, while idle, sees the trigger high after having seen it low on the previous edge.
- R3: `integrating` rises on the edge that ends the charge reset if the trigger is still high, and it falls on the first edge that sees the trigger low. If the trigger is already low when the reset ends, `integrating` never rises in that frame. `integrating` and `cr_pulse` are never high together.
- R4: The first `line_start` (index 0) is asserted on the edge that ends exposure. That is the edge at which the trigger is seen low in EXPOSE, or the end of the reset window when the trigger is already low.
- R5: `line_start` is high for one clock per line. The next line starts on the edge that samples `line_done` high while the sequencer is waiting. `line_done` is ignored in every other state, including the line-start cycle, idle, charge reset and exposure.
- R6: `line_idx` keeps the value of the current line from its start until the next line starts. After a frame it keeps 5355 until the next frame begins, and the next frame starts again at 0.
- R7: `frame_done` is a one-clock pulse. It is asserted on the edge that accepts the `line_done` of line 5355, and the sequencer is idle on the following edge.
- R8: Trigger rising edges seen during charge reset, exposure or readout start no new frame and produce no `cr_pulse`. A trigger that is still high when a frame ends must fall and rise again to start the next frame.
- R9: `sub_en` is sampled at frame start. In a subsampled frame, `line_skip` is 1 for an active line whose offset (index minus 6) is not a multiple of SUB_STEP (default 2). `line_skip` is always 0 for black lines and in frames that are not subsampled.
- R10: After reset all outputs are 0 and `line_idx` is 0. A trigger that is already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Exposure trigger; high level bounds integration |
| sub_en | input | 1 | Subsampling mode request, sampled at frame start |
| line_done | input | 1 | Completion strobe from the line-timing block |
| cr_pulse | output | 1 | Charge-reset strobe |
| integrating | output | 1 | Exposure in progress |
| line_start | output | 1 | One-clock request to run one line |
| line_idx | output | 13 | Index of the current line, 0 to 5355 |
| line_active | output | 1 | Current line lies in the active region |
| line_skip | output | 1 | Shift this line without transfer |
| frame_done | output | 1 | One-clock end-of-frame pulse |

## Verification
Every result appears one clock edge after its cause:
- `cr_pulse` one edge after the trigger is seen high in idle;
- `integrating` or the first `line_start` one edge after the reset window ends;
- each further `line_start` one edge after an accepted `line_done`;
- `frame_done` one edge after the last accepted `line_done`.

The bench drives inputs just after the rising edge. A behavioural model updates on the same edge from the same sampled inputs, and every output is compared on the falling edge, so each check lands in the cycle the result is due. Per-frame tallies of reset length, line-start count, index order and skip count are checked when `frame_done` appears.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_CLEAR  = 3'd1,
        SEQ_EXPOSE = 3'd2,
        SEQ_ISSUE  = 3'd3,
        SEQ_WAIT   = 3'd4,
        SEQ_DONE   = 3'd5
    } seq_state_t;

endpackage

// File: rtl/ccdseq_trig_edge.sv
module ccdseq_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);
    logic trig_q;

    // Resets to 1 so that a trigger held high through reset is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b1;
        else        trig_q <= trig_in;
    end

    assign trig_rise = trig_in & ~trig_q;
endmodule

// File: rtl/ccdseq_cr_timer.sv
module ccdseq_cr_timer #(
    parameter int CR_CLKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CR_W = (CR_CLKS > 1) ? $clog2(CR_CLKS) : 1;
    localparam logic [CR_W-1:0] CR_END = CR_W'(CR_CLKS - 1);

    logic [CR_W-1:0] cnt;

    assign last = run && (cnt == CR_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (last)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // R2: reset window count stays inside its programmed length
    assert_cr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < CR_CLKS);

    // R2: counter only moves while the window is open
    assert_cr_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/ccdseq_line_track.sv
module ccdseq_line_track #(
    parameter int N_HEAD   = 6,
    parameter int N_ACT    = 5344,
    parameter int N_TAIL   = 6,
    parameter int SUB_STEP = 2,
    localparam int N_LINES = N_HEAD + N_ACT + N_TAIL,
    localparam int LINE_W  = $clog2(N_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic              sub_req,
    output logic [LINE_W-1:0] idx,
    output logic              is_last,
    output logic              is_active,
    output logic              skip
);
    localparam int SUB_W = (SUB_STEP > 1) ? $clog2(SUB_STEP) : 1;
    localparam logic [LINE_W-1:0] FIRST_ACT = LINE_W'(N_HEAD);
    localparam logic [LINE_W-1:0] END_ACT   = LINE_W'(N_HEAD + N_ACT);
    localparam logic [LINE_W-1:0] LAST_IDX  = LINE_W'(N_LINES - 1);
    localparam logic [SUB_W-1:0]  SUB_END   = SUB_W'(SUB_STEP - 1);

    logic             sub_mode;
    logic [SUB_W-1:0] sub_cnt;

    assign is_last   = (idx == LAST_IDX);
    assign is_active = (idx >= FIRST_ACT) && (idx < END_ACT);

    generate
        if (SUB_STEP > 1) begin : g_sub
            assign skip = sub_mode && is_active && (sub_cnt != '0);
        end else begin : g_nosub
            assign skip = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            sub_mode <= 1'b0;
            sub_cnt  <= '0;
        end else if (load) begin
            idx      <= '0;
            sub_mode <= sub_req;
            sub_cnt  <= '0;
        end else if (advance) begin
            if (!is_last) idx <= idx + 1'b1;
            if (is_active) sub_cnt <= (sub_cnt == SUB_END) ? '0 : sub_cnt + 1'b1;
        end
    end

    // R1: index never leaves the frame
    assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx) < N_LINES);

    // R6: index holds unless a line is advanced or a frame loaded
    assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(idx));

    // R9: skip tag only on active lines
    assert_skip_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> is_active);
endmodule

// File: rtl/ccd_frame_sequencer.sv
module ccd_frame_sequencer
    import ccdseq_pkg::*;
#(
    parameter int CR_CLKS  = 500,
    parameter int N_HEAD   = 6,
    parameter int N_ACT    = 5344,
    parameter int N_TAIL   = 6,
    parameter int SUB_STEP = 2,
    localparam int N_LINES = N_HEAD + N_ACT + N_TAIL,
    localparam int LINE_W  = $clog2(N_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              sub_en,
    input  logic              line_done,
    output logic              cr_pulse,
    output logic              integrating,
    output logic              line_start,
    output logic [LINE_W-1:0] line_idx,
    output logic              line_active,
    output logic              line_skip,
    output logic              frame_done
);
    seq_state_t state, state_nxt;

    logic trig_rise;
    logic cr_last;
    logic frame_load;
    logic line_adv;
    logic is_last;

    ccdseq_trig_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_rise (trig_rise)
    );

    ccdseq_cr_timer #(.CR_CLKS(CR_CLKS)) u_cr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == SEQ_CLEAR),
        .last  (cr_last)
    );

    ccdseq_line_track #(
        .N_HEAD   (N_HEAD),
        .N_ACT    (N_ACT),
        .N_TAIL   (N_TAIL),
        .SUB_STEP (SUB_STEP)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_load),
        .advance   (line_adv),
        .sub_req   (sub_en),
        .idx       (line_idx),
        .is_last   (is_last),
        .is_active (line_active),
        .skip      (line_skip)
    );

    assign frame_load = (state == SEQ_IDLE) && trig_rise;
    assign line_adv   = (state == SEQ_WAIT) && line_done;

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_IDLE:   if (trig_rise) state_nxt = SEQ_CLEAR;
            SEQ_CLEAR:  if (cr_last)   state_nxt = trig_in ? SEQ_EXPOSE : SEQ_ISSUE;
            SEQ_EXPOSE: if (!trig_in)  state_nxt = SEQ_ISSUE;
            SEQ_ISSUE:                 state_nxt = SEQ_WAIT;
            SEQ_WAIT:   if (line_done) state_nxt = is_last ? SEQ_DONE : SEQ_ISSUE;
            SEQ_DONE:                  state_nxt = SEQ_IDLE;
            default:                   state_nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        cr_pulse    = (state == SEQ_CLEAR);
        integrating = (state == SEQ_EXPOSE);
        line_start  = (state == SEQ_ISSUE);
        frame_done  = (state == SEQ_DONE);
    end

    // R2: a reset window opens only from idle
    assert_cr_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cr_pulse) |-> $past(state == SEQ_IDLE));

    // R3: exposure and charge reset exclusive
    assert_cr_integ_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cr_pulse && integrating));

    // R3: exposure ends once the trigger is seen low
    assert_integ_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (integrating && !trig_in) |=> !integrating);

    // R5: line request lasts one clock
    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

    // R7: frame-done is a single clock followed by idle outputs
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !line_start && !cr_pulse));

    // R8: no new reset window while a frame is running
    assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WAIT || state == SEQ_EXPOSE) |=> !cr_pulse);
endmodule

// File: tb/tb_ccd_frame_sequencer.sv
module tb_ccd_frame_sequencer;
    localparam int CR      = 500;
    localparam int NH      = 6;
    localparam int NA      = 5344;
    localparam int NT      = 6;
    localparam int STEP    = 2;
    localparam int NL      = NH + NA + NT;
    localparam int WDOG    = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        sub_en = 1'b0;
    logic        line_done = 1'b0;
    logic        cr_pulse, integrating, line_start, line_active, line_skip, frame_done;
    logic [12:0] line_idx;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit poke = 0;
    bit resp_on = 1;

    always #2 clk = ~clk;

    ccd_frame_sequencer #(
        .CR_CLKS(CR), .N_HEAD(NH), .N_ACT(NA), .N_TAIL(NT), .SUB_STEP(STEP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig), .sub_en(sub_en),
        .line_done(line_done), .cr_pulse(cr_pulse), .integrating(integrating),
        .line_start(line_start), .line_idx(line_idx), .line_active(line_active),
        .line_skip(line_skip), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle,1 clear,2 expose,3 start,4 wait,5 done
    int  m_ph = 0, m_cnt = 0, m_line = 0;
    bit  m_trq = 1, m_sub = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_line = 0; m_trq = 1; m_sub = 0;
        end else begin
            case (m_ph)
                0: if (trig && !m_trq) begin m_ph = 1; m_cnt = 0; m_line = 0; m_sub = sub_en; end
                1: if (m_cnt == CR - 1) begin m_cnt = 0; m_ph = trig ? 2 : 3; end
                   else m_cnt++;
                2: if (!trig) m_ph = 3;
                3: m_ph = 4;
                4: if (line_done) begin
                       if (m_line == NL - 1) m_ph = 5;
                       else begin m_line++; m_ph = 3; end
                   end
                default: m_ph = 0;
            endcase
            m_trq = trig;
        end
    end

    // Per-frame tallies
    int f_cr = 0, f_starts = 0, f_skips = 0, f_prev = -1, f_sub = 0;
    int exp_skips;

    function automatic int skip_total();
        int s = 0;
        for (int i = NH; i < NH + NA; i++) if (((i - NH) % STEP) != 0) s++;
        return s;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_act;
            bit e_skip;
            e_act  = (m_line >= NH) && (m_line < NH + NA);
            e_skip = m_sub && e_act && (((m_line - NH) % STEP) != 0);
            chk(cr_pulse    == (m_ph == 1), "R2 cr_pulse", cr_pulse, m_ph == 1);
            chk(integrating == (m_ph == 2), "R3 integrating", integrating, m_ph == 2);
            chk(line_start  == (m_ph == 3), "R5 line_start", line_start, m_ph == 3);
            chk(int'(line_idx) == m_line, "R6 line_idx", line_idx, m_line);
            chk(line_active == e_act, "R1 line_active", line_active, e_act);
            chk(line_skip   == e_skip, "R9 line_skip", line_skip, e_skip);
            chk(frame_done  == (m_ph == 5), "R7 frame_done", frame_done, m_ph == 5);

            if (cr_pulse) begin
                if (f_cr == 0) f_sub = m_sub;
                f_cr++;
            end
            if (line_start) begin
                chk(int'(line_idx) == f_prev + 1, "R1 index order", line_idx, f_prev + 1);
                f_prev = line_idx;
                f_starts++;
                if (line_skip) f_skips++;
            end
            if (frame_done) begin
                exp_skips = f_sub ? skip_total() : 0;
                chk(f_cr == CR, "R2 reset length", f_cr, CR);
                chk(f_starts == NL, "R1 line count", f_starts, NL);
                chk(f_skips == exp_skips, "R9 skip count", f_skips, exp_skips);
                f_cr = 0; f_starts = 0; f_skips = 0; f_prev = -1;
            end
        end
    end

    // Line-timing responder: done 2..4 clocks after each start, plus stray pulses
    int wcnt = -1;
    int nresp = 0;
    initial begin
        forever begin
            @(posedge clk); #1;
            line_done = 1'b0;
            if (poke) begin line_done = 1'b1; poke = 0; end
            if (wcnt == 0) line_done = 1'b1;
            if (wcnt >= 0) wcnt--;
            if (line_start && resp_on) begin
                wcnt = 1 + (nresp % 3);
                nresp++;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_frame();
        while (!frame_done && cyc < WDOG) @(negedge clk);
        step(1);
    endtask

    initial begin
        trig = 1'b1;           // held high through reset: R10 says no edge
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!cr_pulse && !integrating && !line_start && !frame_done && !line_skip && !line_active,
            "R10 reset outputs", {cr_pulse, integrating, line_start, frame_done}, 0);
        chk(line_idx == 0, "R10 reset index", line_idx, 0);
        step(5);
        chk(!cr_pulse, "R10 high trigger no edge", cr_pulse, 0);
        trig = 1'b0;
        step(4);

        // Frame A: long exposure, stray line_done during idle and exposure (R5)
        poke = 1; step(3);
        sub_en = 1'b0;
        trig = 1'b1;
        step(CR + 30);
        chk(integrating, "R3 exposure active", integrating, 1);
        poke = 1; step(3);
        trig = 1'b0;
        wait_frame();
        chk(line_idx == NL - 1, "R6 index after frame", line_idx, NL - 1);

        // Frame B: subsampled, trigger shorter than reset, retriggers in readout (R4, R8, R9)
        step(5);
        sub_en = 1'b1;
        trig = 1'b1; step(3); trig = 1'b0;
        sub_en = 1'b0;
        step(CR + 200);
        trig = 1'b1; step(5); trig = 1'b0; step(50);
        trig = 1'b1; step(2); trig = 1'b0;
        wait_frame();

        // Frame C: trigger re-raised during readout and held past frame end (R8)
        step(5);
        trig = 1'b1; step(CR + 10); trig = 1'b0;
        step(1000);
        trig = 1'b1;
        wait_frame();
        step(30);
        chk(!cr_pulse && !line_start, "R8 held trigger no restart", cr_pulse, 0);

        // Frame D: fall then rise starts a fresh frame at index 0
        trig = 1'b0; step(3);
        trig = 1'b1; step(2);
        chk(cr_pulse, "R2 fresh frame reset", cr_pulse, 1);
        chk(line_idx == 0, "R6 index restarts", line_idx, 0);
        trig = 1'b0;
        wait_frame();
        step(5);

        if (cyc >= WDOG) chk(0, "watchdog", cyc, WDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= WDOG + 1000);
        chk(0, "watchdog", cyc, WDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule